// File: doc/BRIEF.md
# Byte-Sequenced Conversion Result Readout

This block is the host-facing sequencer in front of a slow integrating converter core. It returns a result of up to 24 bits over a narrow byte-wide bus, and a single active-low convert strobe serves two purposes. From the ready state, a falling edge on the strobe asks the core to start a new conversion. Once a result is present, the next falling edges step the bus register from the high byte to the middle byte and then to the low byte. A two-bit status code tells the host which phase the block is in: busy (00), high byte shown (01), middle byte shown (10), or low byte shown and ready (11).

An active-low auto-zero input aborts whatever is in progress and requests an offset calibration from the core. While it is held low, and for a fixed number of cycles after it is released, the status lines are not driven. The block then drives busy until the core reports that the calibration is done, and after that it reports ready. The 22-bit result is offset binary. It is zero-extended into three bytes, so the unused top bits of the high byte read as zero.

The block drives no tri-state buffers itself. The status pair and the data byte each come with a drive-enable output, for the pad cells at the chip edge. The data enable follows the active-low output-enable pin combinationally.

Top module: `cvt_readout`

## Requirements
- R1: While `rst_n` is low, or while `az_n_i` is low after its synchronizer, `st_en_o` is 0, `st_o` is 00 and no request pulses are issued. After both are high, `st_en_o` stays 0 for `HOLD_CYC` cycles. It then rises in the same cycle as a single one-cycle `core_az_o` pulse, and `st_o` reads 00.
- R2: During calibration (status 00 following `core_az_o`), a `core_valid_i` pulse moves the status to 11 (ready) and leaves `bus_d_o` unchanged. `bus_d_o` is 0 after `rst_n`.
- R3: `cvt_n_i` passes through `SYNC_STAGES` flops. Only a one-to-zero transition acts, and it acts once: a level held low, or a rising edge, causes no further step.
- R4: In status 11, a convert falling edge gives a one-cycle `core_start_o` pulse, and the status becomes 00 in that same cycle.
- R5: Convert falling edges that arrive while the status is 00 (calibration or conversion in progress) are ignored: no status change and no start pulse.
- R6: A `core_valid_i` pulse during a conversion loads the high byte onto `bus_d_o` and sets the status to 01. The high byte is bits [23:16] of the result zero-extended to 24 bits, so its top two bits are 0.
- R7: In status 01, a convert falling edge loads result bits [15:8] onto `bus_d_o` and sets the status to 10.
- R8: In status 10, a convert falling edge loads result bits [7:0] onto `bus_d_o` and sets the status to 11.
- R9: `bus_en_o` is the inverse of `oe_n_i` at all times and has no effect on `bus_d_o` or on the status.
- R10: A `core_valid_i` pulse outside calibration and conversion is ignored: `bus_d_o` and the status keep their values.
- R11: Driving `az_n_i` low in any readout phase aborts it (R1 applies from that point), and calibration restarts after release. `bus_d_o` keeps its last value throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cvt_n_i | input | 1 | Asynchronous convert strobe, acts on falling edge |
| oe_n_i | input | 1 | Active-low data output enable |
| az_n_i | input | 1 | Asynchronous active-low auto-zero / abort |
| core_valid_i | input | 1 | One-cycle pulse from the core: result ready or calibration done |
| core_res_i | input | RES_W | Offset-binary result, sampled with core_valid_i |
| core_start_o | output | 1 | One-cycle request to start a conversion |
| core_az_o | output | 1 | One-cycle request to run an offset calibration |
| st_o | output | 2 | Status code (00 busy, 01 high, 10 middle, 11 low/ready) |
| st_en_o | output | 1 | Drive enable for the status pads |
| bus_d_o | output | BYTE_W | Byte register value for the data pads |
| bus_en_o | output | 1 | Drive enable for the data pads |

## Verification
The assertions assume that `core_valid_i` is a single-cycle pulse synchronous to `clk` and that `core_res_i` is stable in that cycle. They also assume the convert strobe holds each level for at least `SYNC_STAGES` + 1 cycles, so the synchronizer sees every edge. The bench keeps every convert level for four cycles and raises `core_valid_i` for exactly one cycle. It drives all inputs one nanosecond after the rising edge. The abort, held-low and pulse-while-busy cases are sent on purpose, in calibration, conversion and readout phases.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

   localparam int NBYTES = 3;

   typedef enum logic [2:0] {
      PH_HOLD,
      PH_CAL,
      PH_CONV,
      PH_HI,
      PH_MID,
      PH_LO
   } phase_e;

   typedef enum logic [1:0] {
      SEL_LO  = 2'd0,
      SEL_MID = 2'd1,
      SEL_HI  = 2'd2
   } bsel_e;

   function automatic logic [1:0] phase_code(phase_e p);
      case (p)
         PH_HI:   return 2'b01;
         PH_MID:  return 2'b10;
         PH_LO:   return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/rdo_sync.sv
module rdo_sync #(
   parameter int STAGES   = 2,
   parameter bit RST_VAL  = 1'b1,
   parameter bit FALL_DET = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   localparam int LEN = FALL_DET ? STAGES + 1 : STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rdo_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LEN-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {LEN{RST_VAL}};
      else        sh <= {sh[LEN-2:0], d_i};
   end

   generate
      if (FALL_DET) begin : g_fall
         assign q_o = sh[STAGES] & ~sh[STAGES-1];

         // R3: an edge yields exactly one detect cycle
         p_fall_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
            q_o |=> !q_o);
      end else begin : g_level
         assign q_o = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rdo_bytes.sv
module rdo_bytes import rdo_pkg::*; #(
   parameter int RES_W  = 22,
   parameter int BYTE_W = 8
)(
   input  logic [RES_W-1:0]  res_i,
   input  bsel_e             sel_i,
   output logic [BYTE_W-1:0] byte_o
);
   localparam int FULL_W = NBYTES * BYTE_W;
   localparam int PAD_W  = FULL_W - RES_W;

   logic [FULL_W-1:0] full;
   logic [BYTE_W-1:0] slice [NBYTES];

   generate
      if (PAD_W > 0) begin : g_pad
         assign full = {{PAD_W{1'b0}}, res_i};
      end else begin : g_nopad
         assign full = res_i;
      end
      for (genvar k = 0; k < NBYTES; k++) begin : g_slice
         assign slice[k] = full[k*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_comb begin
      case (sel_i)
         SEL_HI:  byte_o = slice[2];
         SEL_MID: byte_o = slice[1];
         default: byte_o = slice[0];
      endcase
   end

endmodule

// File: rtl/rdo_fsm.sv
module rdo_fsm import rdo_pkg::*; #(
   parameter int HOLD_CYC = 16
)(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   az_ok_i,
   input  logic   fall_i,
   input  logic   valid_i,
   output phase_e ph_o,
   output logic   cap_o,
   output logic   ld_o,
   output bsel_e  sel_o,
   output logic   start_o,
   output logic   az_req_o
);
   localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("rdo_fsm: HOLD_CYC must be at least 1");
      end
   endgenerate

   phase_e           ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             start_d, az_d;

   always_comb begin
      ph_d    = ph_q;
      cnt_d   = cnt_q;
      cap_o   = 1'b0;
      ld_o    = 1'b0;
      sel_o   = SEL_HI;
      start_d = 1'b0;
      az_d    = 1'b0;
      if (!az_ok_i) begin
         ph_d  = PH_HOLD;
         cnt_d = '0;
      end else begin
         case (ph_q)
            PH_HOLD: begin
               if (cnt_q == CNT_LAST) begin
                  ph_d  = PH_CAL;
                  cnt_d = '0;
                  az_d  = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_CAL: if (valid_i) ph_d = PH_LO;
            PH_CONV: begin
               if (valid_i) begin
                  ph_d  = PH_HI;
                  cap_o = 1'b1;
                  ld_o  = 1'b1;
                  sel_o = SEL_HI;
               end
            end
            PH_HI: begin
               if (fall_i) begin
                  ph_d  = PH_MID;
                  ld_o  = 1'b1;
                  sel_o = SEL_MID;
               end
            end
            PH_MID: begin
               if (fall_i) begin
                  ph_d  = PH_LO;
                  ld_o  = 1'b1;
                  sel_o = SEL_LO;
               end
            end
            PH_LO: begin
               if (fall_i) begin
                  ph_d    = PH_CONV;
                  start_d = 1'b1;
               end
            end
            default: ph_d = PH_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_HOLD;
         cnt_q    <= '0;
         start_o  <= 1'b0;
         az_req_o <= 1'b0;
      end else begin
         ph_q     <= ph_d;
         cnt_q    <= cnt_d;
         start_o  <= start_d;
         az_req_o <= az_d;
      end
   end

   assign ph_o = ph_q;

   // R1: calibration request is a single-cycle pulse
   p_az_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      az_req_o |=> !az_req_o);

   // R4: start request is a single-cycle pulse
   p_start_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

endmodule

// File: rtl/cvt_readout.sv
module cvt_readout import rdo_pkg::*; #(
   parameter int RES_W       = 22,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cvt_n_i,
   input  logic              oe_n_i,
   input  logic              az_n_i,
   input  logic              core_valid_i,
   input  logic [RES_W-1:0]  core_res_i,
   output logic              core_start_o,
   output logic              core_az_o,
   output logic [1:0]        st_o,
   output logic              st_en_o,
   output logic [BYTE_W-1:0] bus_d_o,
   output logic              bus_en_o
);
   localparam int PAD_W = NBYTES * BYTE_W - RES_W;

   generate
      if (RES_W <= (NBYTES - 1) * BYTE_W || PAD_W < 0) begin : g_bad_width
         $error("cvt_readout: RES_W must need exactly three bytes");
      end
   endgenerate

   logic              cvt_fall;
   logic              az_ok;
   logic              cap;
   logic              ld;
   bsel_e             sel;
   phase_e            ph;
   logic [RES_W-1:0]  res_q;
   logic [RES_W-1:0]  res_src;
   logic [BYTE_W-1:0] byte_nx;

   rdo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALL_DET(1'b1)) u_cvt_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cvt_n_i),
      .q_o   (cvt_fall)
   );

   rdo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL_DET(1'b0)) u_az_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (az_n_i),
      .q_o   (az_ok)
   );

   rdo_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .az_ok_i  (az_ok),
      .fall_i   (cvt_fall),
      .valid_i  (core_valid_i),
      .ph_o     (ph),
      .cap_o    (cap),
      .ld_o     (ld),
      .sel_o    (sel),
      .start_o  (core_start_o),
      .az_req_o (core_az_o)
   );

   assign res_src = cap ? core_res_i : res_q;

   rdo_bytes #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_bytes (
      .res_i  (res_src),
      .sel_i  (sel),
      .byte_o (byte_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         bus_d_o <= '0;
      end else begin
         if (cap) res_q   <= core_res_i;
         if (ld)  bus_d_o <= byte_nx;
      end
   end

   assign st_o     = phase_code(ph);
   assign st_en_o  = (ph != PH_HOLD);
   assign bus_en_o = ~oe_n_i;

   // R1: status drive starts together with the calibration request
   p_en_with_az_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_en_o) |-> core_az_o);

   // R4: a start request coincides with a driven busy status
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |-> (st_en_o && st_o == 2'b00));

   // R5: edges seen while busy and without a core pulse leave status at busy
   p_busy_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o == 2'b00 && cvt_fall && !core_valid_i) |=> (st_o == 2'b00));

   // R10: with neither an edge nor a core pulse the byte register holds
   p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_valid_i && !cvt_fall) |=> $stable(bus_d_o));

   generate
      if (PAD_W > 0) begin : g_pad_chk
         // R6: unused top bits of the high byte read as zero
         p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_en_o && st_o == 2'b01) |-> (bus_d_o[BYTE_W-1 -: PAD_W] == '0));
      end
   endgenerate

endmodule

// File: tb/tb_cvt_readout.sv
module tb_cvt_readout;
   localparam int RES_W  = 22;
   localparam int BYTE_W = 8;
   localparam int SYNC   = 2;
   localparam int HOLD   = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             cvt_n = 1'b1;
   logic             oe_n = 1'b1;
   logic             az_n = 1'b1;
   logic             core_valid = 1'b0;
   logic [RES_W-1:0] core_res = '0;
   logic             core_start, core_az, st_en, bus_en;
   logic [1:0]       st;
   logic [7:0]       bus_d;

   cvt_readout dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cvt_n_i      (cvt_n),
      .oe_n_i       (oe_n),
      .az_n_i       (az_n),
      .core_valid_i (core_valid),
      .core_res_i   (core_res),
      .core_start_o (core_start),
      .core_az_o    (core_az),
      .st_o         (st),
      .st_en_o      (st_en),
      .bus_d_o      (bus_d),
      .bus_en_o     (bus_en)
   );

   int checks = 0;
   int errors = 0;
   int n_start = 0;
   int n_az = 0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural reference: phase 0 hold,1 cal,2 conv,3 high,4 mid,5 low/ready
   bit   mc [0:SYNC];
   bit   ma [0:SYNC-1];
   int   m_ph, m_cnt;
   int   m_bus;
   bit   m_start, m_az, m_f, m_ok;
   logic [RES_W-1:0] m_res;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= SYNC; i++) mc[i] = 1'b1;
         for (int i = 0; i < SYNC; i++) ma[i] = 1'b0;
         m_ph = 0; m_cnt = 0; m_bus = 0; m_start = 0; m_az = 0; m_res = '0;
      end else begin
         m_f = mc[SYNC] && !mc[SYNC-1];
         m_ok = ma[SYNC-1];
         m_start = 0;
         m_az = 0;
         if (!m_ok) begin
            m_ph = 0; m_cnt = 0;
         end else if (m_ph == 0) begin
            if (m_cnt == HOLD - 1) begin m_ph = 1; m_cnt = 0; m_az = 1; end
            else m_cnt++;
         end else if (m_ph == 1) begin
            if (core_valid) m_ph = 5;
         end else if (m_ph == 2) begin
            if (core_valid) begin m_ph = 3; m_res = core_res; m_bus = int'(core_res >> 16) & 8'hFF; end
         end else if (m_ph == 3) begin
            if (m_f) begin m_ph = 4; m_bus = int'(m_res >> 8) & 8'hFF; end
         end else if (m_ph == 4) begin
            if (m_f) begin m_ph = 5; m_bus = int'(m_res) & 8'hFF; end
         end else begin
            if (m_f) begin m_ph = 2; m_start = 1; end
         end
         for (int i = SYNC; i > 0; i--) mc[i] = mc[i-1];
         mc[0] = cvt_n;
         for (int i = SYNC - 1; i > 0; i--) ma[i] = ma[i-1];
         ma[0] = az_n;
      end
   end

   function automatic int exp_st(int p);
      return (p == 3) ? 1 : (p == 4) ? 2 : (p == 5) ? 3 : 0;
   endfunction

   // per-cycle comparison, half a period after each edge
   always @(negedge clk) begin
      chk("R1", "st_en", int'(st_en), int'(m_ph != 0));
      chk("R5", "status", int'(st), exp_st(m_ph));
      chk("R6", "bus byte", int'(bus_d), m_bus);
      chk("R4", "start", int'(core_start), int'(m_start));
      chk("R1", "az req", int'(core_az), int'(m_az));
      chk("R9", "bus_en", int'(bus_en), int'(!oe_n));
      if (core_start) n_start++;
      if (core_az) n_az++;
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cvt_pulse();
      cvt_n = 1'b0; tick(4);
      cvt_n = 1'b1; tick(4);
   endtask

   task automatic core_pulse(logic [RES_W-1:0] v);
      core_res = v; core_valid = 1'b1; tick(1);
      core_valid = 1'b0; tick(5);
   endtask

   task automatic readout(logic [RES_W-1:0] v);
      int s0;
      s0 = n_start;
      cvt_pulse();
      chk("R4", "status after start", int'(st), 0);
      chk("R4", "start count", n_start, s0 + 1);
      cvt_pulse();
      chk("R5", "status busy pulse", int'(st), 0);
      chk("R5", "start count busy", n_start, s0 + 1);
      core_pulse(v);
      chk("R6", "status high", int'(st), 1);
      chk("R6", "high byte", int'(bus_d), int'(v >> 16));
      core_pulse(~v);
      chk("R10", "status stray valid", int'(st), 1);
      chk("R10", "byte stray valid", int'(bus_d), int'(v >> 16));
      cvt_pulse();
      chk("R7", "status mid", int'(st), 2);
      chk("R7", "mid byte", int'(bus_d), int'(v[15:8]));
      cvt_pulse();
      chk("R8", "status low", int'(st), 3);
      chk("R8", "low byte", int'(bus_d), int'(v[7:0]));
   endtask

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int s0;
      tick(5);
      chk("R1", "en in reset", int'(st_en), 0);
      chk("R2", "bus in reset", int'(bus_d), 0);
      rst_n = 1'b1;
      tick(3);
      chk("R1", "en during hold", int'(st_en), 0);
      tick(HOLD + 4);
      chk("R1", "en after hold", int'(st_en), 1);
      chk("R1", "az pulses", n_az, 1);
      chk("R2", "calibrating status", int'(st), 0);
      cvt_pulse();
      chk("R5", "cal ignores convert", int'(st), 0);
      chk("R5", "no start in cal", n_start, 0);
      core_pulse(22'h155555);
      chk("R2", "ready after cal", int'(st), 3);
      chk("R2", "bus untouched by cal", int'(bus_d), 0);

      oe_n = 1'b0; tick(1);
      chk("R9", "bus enabled", int'(bus_en), 1);
      readout(22'h200000);
      readout(22'h3FFFFF);
      oe_n = 1'b1; tick(1);
      chk("R9", "bus disabled", int'(bus_en), 0);
      chk("R9", "data kept", int'(bus_d), 8'hFF);
      readout(22'h000000);
      readout(22'h2A5C3E);

      // R3: one long low level is one edge only
      s0 = n_start;
      cvt_n = 1'b0; tick(12);
      chk("R3", "single start on long low", n_start, s0 + 1);
      core_pulse(22'h1234AB);
      tick(10);
      chk("R3", "held low no step", int'(st), 1);
      cvt_n = 1'b1; tick(10);
      chk("R3", "rising edge no step", int'(st), 1);
      cvt_pulse();
      chk("R7", "mid after long low", int'(bus_d), 8'h34);

      // R11: abort in the middle-byte phase
      az_n = 1'b0; tick(4);
      chk("R11", "en dropped", int'(st_en), 0);
      tick(10);
      chk("R11", "en still low", int'(st_en), 0);
      chk("R11", "bus kept", int'(bus_d), 8'h34);
      az_n = 1'b1; tick(SYNC + HOLD + 3);
      chk("R11", "en back", int'(st_en), 1);
      chk("R11", "status busy", int'(st), 0);
      chk("R11", "second az", n_az, 2);
      core_pulse('0);
      chk("R11", "ready again", int'(st), 3);
      readout(22'h0F0F0F);
      tick(5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule